// File: doc/BRIEF.md
# Dual-Strobe Page-Mode DRAM Cycle Decoder

This block is a clock-sampled, synthesizable model of the memory side of a page-mode DRAM whose column strobe is split into a lower-byte and an upper-byte strobe. It sits on a controller's strobe, address and data pins inside a verification or emulation environment. It samples the row strobe, both column strobes, write enable, output enable and the shared address pins on every rising clock edge. From the order of strobe edges it works out what kind of memory cycle the controller started.

Each decided cycle is reported for one clock as a 3-bit code. Reads return data from a small parameterised word store, one byte-enable per lane. Writes update only the lanes whose strobe is active. A violation flag pulses when the row strobe is held low too briefly, or when it is precharged too briefly before the next fall. All timing is measured in sampled clock edges.

Top module: `dcas_dram_model`

## Requirements
- R1: The internal column strobe is active while either lane strobe is low and goes inactive only once both are high. A lane strobe rising while the other stays low neither ends the access nor starts a new one.
- R2: In an open row, an internal column strobe fall with write enable high reports code 1 (read) with `cyc_valid` high for exactly one clock. `dq_out` then holds the word at index row*2^COL_W + column.
- R3: `dq_oe[0]` enables bits 7:0 and follows `lcas_n`. `dq_oe[1]` enables bits 15:8 and follows `ucas_n`. A lane is driven only while read data is live, its own strobe is low and `oe_n` is low.
- R4: Write enable already low at the internal column strobe fall reports code 2 (early write). It stores `dq_in` into the lanes whose strobe is low, and both enables stay low for the whole access.
- R5: Write enable falling during a read access reports code 3 (read-write). It stores `dq_in` into the lanes whose strobe is low at that edge, at the latched column, and turns the outputs off.
- R6: A row strobe fall while the internal column strobe is already low, from standby, reports code 5 (CBR refresh). The address is ignored, nothing is stored and the outputs stay off.
- R7: A row strobe that rises and falls again while the column strobe is held low after an access reports code 6 (hidden refresh). The earlier read data stays driven throughout.
- R8: A row cycle that ends without any column strobe fall reports code 4 (row-only refresh) at the row strobe rise, with the outputs off.
- R9: With the row strobe and both lane strobes high, both enables are low.
- R10: Several column strobe pulses under one low row strobe access successive columns of the latched row (page mode).
- R11: `viol` pulses for one clock at a row strobe rise if the strobe was sampled low on fewer than RAS_MIN edges.
- R12: `viol` pulses for one clock at a row strobe fall if the strobe was sampled high on fewer than PRE_MIN edges since its last rise.
- R13: After reset `dq_oe`, `cyc_valid` and `viol` are low.
- R14: Raising `oe_n` during a read turns the enables off without ending the access. Lowering it again restores the same data with no new report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_W,COL_W) | Shared row/column address pins |
| dq_in | input | DW | Write data from the controller |
| dq_out | output | DW | Read data toward the controller |
| dq_oe | output | 2 | Per-lane output enable |
| cyc_valid | output | 1 | One-clock pulse when a cycle type is decided |
| cyc_type | output | 3 | Decided cycle code (0 standby ... 6 hidden refresh) |
| viol | output | 1 | One-clock pulse on a row strobe width violation |

## Verification
Every result is registered once. It appears on the ports at the very rising edge that first samples the pin change causing it, so each result is due zero clocks after that sampling edge. The bench moves pins one time unit after a rising edge and reads the outputs one time unit after the next rising edge, which is the first moment the reaction can be seen. Row strobe widths are counted in sampled edges, so the bench holds each phase for an exact number of edges to land just inside or just outside RAS_MIN and PRE_MIN.

// File: rtl/dcas_pkg.sv
package dcas_pkg;

  typedef enum logic [2:0] {
    CYC_STANDBY = 3'd0,
    CYC_READ    = 3'd1,
    CYC_EWRITE  = 3'd2,
    CYC_RWRITE  = 3'd3,
    CYC_RASONLY = 3'd4,
    CYC_CBR     = 3'd5,
    CYC_HIDDEN  = 3'd6
  } cyc_e;

  typedef enum logic [2:0] {
    M_IDLE    = 3'd0,
    M_ROW     = 3'd1,
    M_ACCESS  = 3'd2,
    M_HOLD    = 3'd3,
    M_REF_CBR = 3'd4,
    M_REF_HID = 3'd5
  } mode_e;

  // linear word index of a row/column pair
  function automatic int unsigned word_at(input int unsigned row, input int unsigned col,
                                          input int unsigned col_w);
    return (row << col_w) | col;
  endfunction

  // internal column strobe is active when any lane strobe is low
  function automatic logic strobe_active(input logic [1:0] lane_n);
    return ~&lane_n;
  endfunction

endpackage

// File: rtl/dcas_pin_sampler.sv
module dcas_pin_sampler
  import dcas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic [1:0] lane_n,
  input  logic       we_n,
  output logic       ras_fall,
  output logic       ras_rise,
  output logic       cas_fall,
  output logic       cas_rise,
  output logic       we_fall,
  output logic       cas_act
);
  logic ras_q, cas_q, we_q;

  assign cas_act = strobe_active(lane_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b0;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_act;
      we_q  <= we_n;
    end
  end

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = ~cas_q & cas_act;
  assign cas_rise = cas_q & ~cas_act;
  assign we_fall  = we_q & ~we_n;
endmodule

// File: rtl/dcas_ras_guard.sv
module dcas_ras_guard #(
  parameter int unsigned RAS_MIN = 4,
  parameter int unsigned PRE_MIN = 3,
  localparam int unsigned LIM = (RAS_MIN > PRE_MIN) ? RAS_MIN : PRE_MIN,
  localparam int unsigned CW  = $clog2(LIM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_fall,
  input  logic ras_rise,
  output logic viol
);
  logic [CW-1:0] run_q;

  function automatic logic too_short(input logic [CW-1:0] n, input int unsigned lim);
    return 32'(n) < lim;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= CW'(LIM);
      viol  <= 1'b0;
    end else begin
      viol <= (ras_rise && too_short(run_q, RAS_MIN)) ||
              (ras_fall && too_short(run_q, PRE_MIN));
      if (ras_rise || ras_fall) run_q <= CW'(1);
      else if (run_q != CW'(LIM)) run_q <= run_q + CW'(1);
    end
  end
endmodule

// File: rtl/dcas_word_store.sv
module dcas_word_store #(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 6,
  localparam int unsigned DEPTH = 1 << IW,
  localparam int unsigned BW = DW / 2
) (
  input  logic          clk,
  input  logic [1:0]    wr_lanes,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [1:0] lanes);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < 2; l++)
      if (lanes[l]) r[l*BW +: BW] = new_w[l*BW +: BW];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (|wr_lanes) mem[wr_idx] <= lane_merge(mem[wr_idx], wr_data, wr_lanes);
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/dcas_cycle_fsm.sv
module dcas_cycle_fsm
  import dcas_pkg::*;
#(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 3,
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int unsigned IW = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic              cas_rise,
  input  logic              we_fall,
  input  logic              cas_act,
  input  logic              ras_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [1:0]        lane_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        wr_lanes,
  output logic [IW-1:0]     wr_idx,
  output logic              rd_en,
  output logic [IW-1:0]     rd_idx,
  output logic [1:0]        dq_oe,
  output logic              cyc_valid,
  output logic [2:0]        cyc_type
);
  mode_e mode_q, mode_n;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic acc_q, acc_n, rdk_q, rdk_n, drv_q, drv_n;
  logic row_ld, col_ld, rep;
  cyc_e rep_t;

  wire [ROW_W-1:0] row_pins = addr[ROW_W-1:0];
  wire [COL_W-1:0] col_pins = addr[COL_W-1:0];
  wire [IW-1:0] idx_pins  = IW'(word_at(32'(row_q), 32'(col_pins), COL_W));
  wire [IW-1:0] idx_latch = IW'(word_at(32'(row_q), 32'(col_q), COL_W));

  always_comb begin
    mode_n = mode_q; acc_n = acc_q; rdk_n = rdk_q; drv_n = drv_q;
    row_ld = 1'b0; col_ld = 1'b0; rep = 1'b0; rep_t = CYC_STANDBY;
    rd_en = 1'b0; wr_lanes = 2'b00; wr_idx = idx_latch; rd_idx = idx_pins;
    unique case (mode_q)
      M_IDLE: if (ras_fall) begin
        if (cas_act) begin
          mode_n = M_REF_CBR; rep = 1'b1; rep_t = CYC_CBR; drv_n = 1'b0;
        end else begin
          mode_n = M_ROW; row_ld = 1'b1; acc_n = 1'b0;
        end
      end
      M_ROW: if (ras_rise) begin
        mode_n = M_IDLE;
        if (!acc_q) begin rep = 1'b1; rep_t = CYC_RASONLY; end
      end else if (cas_fall) begin
        mode_n = M_ACCESS; col_ld = 1'b1; acc_n = 1'b1; rep = 1'b1;
        if (!we_n) begin
          rep_t = CYC_EWRITE; wr_lanes = ~lane_n; wr_idx = idx_pins; rdk_n = 1'b0;
        end else begin
          rep_t = CYC_READ; rd_en = 1'b1; drv_n = 1'b1; rdk_n = 1'b1;
        end
      end
      M_ACCESS: if (cas_rise) begin
        mode_n = ras_n ? M_IDLE : M_ROW;
      end else if (ras_rise) begin
        mode_n = M_HOLD;
      end else if (we_fall && rdk_q) begin
        rep = 1'b1; rep_t = CYC_RWRITE; wr_lanes = ~lane_n; drv_n = 1'b0; rdk_n = 1'b0;
      end
      M_HOLD: if (cas_rise) begin
        mode_n = M_IDLE;
      end else if (ras_fall) begin
        mode_n = M_REF_HID; rep = 1'b1; rep_t = CYC_HIDDEN;
      end
      M_REF_CBR: if (ras_rise) mode_n = M_IDLE;
      M_REF_HID: if (ras_rise) mode_n = cas_act ? M_HOLD : M_IDLE;
      default: mode_n = M_IDLE;
    endcase
    if (cas_rise) drv_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_IDLE; row_q <= '0; col_q <= '0;
      acc_q <= 1'b0; rdk_q <= 1'b0; drv_q <= 1'b0;
      dq_oe <= 2'b00; cyc_valid <= 1'b0; cyc_type <= 3'd0;
    end else begin
      mode_q <= mode_n; acc_q <= acc_n; rdk_q <= rdk_n; drv_q <= drv_n;
      if (row_ld) row_q <= row_pins;
      if (col_ld) col_q <= col_pins;
      dq_oe     <= {2{drv_n & ~oe_n}} & ~lane_n;
      cyc_valid <= rep;
      cyc_type  <= rep_t;
    end
  end
endmodule

// File: rtl/dcas_dram_model.sv
module dcas_dram_model
  import dcas_pkg::*;
#(
  parameter int unsigned ROW_W   = 3,
  parameter int unsigned COL_W   = 3,
  parameter int unsigned DW      = 16,
  parameter int unsigned RAS_MIN = 4,
  parameter int unsigned PRE_MIN = 3,
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int unsigned IW     = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic [1:0]        dq_oe,
  output logic              cyc_valid,
  output logic [2:0]        cyc_type,
  output logic              viol
);
  wire [1:0] lane_n = {ucas_n, lcas_n};
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, cas_act;
  logic [1:0] wr_lanes;
  logic [IW-1:0] wr_idx, rd_idx;
  logic rd_en;

  dcas_pin_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lane_n(lane_n), .we_n(we_n),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .cas_rise(cas_rise), .we_fall(we_fall), .cas_act(cas_act)
  );

  dcas_cycle_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall), .cas_act(cas_act),
    .ras_n(ras_n), .we_n(we_n), .oe_n(oe_n), .lane_n(lane_n), .addr(addr),
    .wr_lanes(wr_lanes), .wr_idx(wr_idx), .rd_en(rd_en), .rd_idx(rd_idx),
    .dq_oe(dq_oe), .cyc_valid(cyc_valid), .cyc_type(cyc_type)
  );

  dcas_word_store #(.DW(DW), .IW(IW)) u_mem (
    .clk(clk), .wr_lanes(wr_lanes), .wr_idx(wr_idx), .wr_data(dq_in),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(dq_out)
  );

  dcas_ras_guard #(.RAS_MIN(RAS_MIN), .PRE_MIN(PRE_MIN)) u_grd (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .ras_rise(ras_rise), .viol(viol)
  );
endmodule

// File: rtl/dcas_dram_checker.sv
module dcas_dram_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       lcas_n,
  input logic       ucas_n,
  input logic       oe_n,
  input logic [1:0] dq_oe,
  input logic       cyc_valid,
  input logic [2:0] cyc_type,
  input logic       viol
);
  // R9
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) && $past(lcas_n) && $past(ucas_n)) |-> dq_oe == 2'b00);
  // R3
  lane_lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> (!$past(lcas_n) && !$past(oe_n)));
  // R3
  lane_hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> (!$past(ucas_n) && !$past(oe_n)));
  // R6
  cbr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd5) |-> dq_oe == 2'b00);
  // R4
  ewrite_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd2) |-> dq_oe == 2'b00);
  // R1
  read_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 3'd1) |-> (!$past(lcas_n) || !$past(ucas_n)));
  // R2
  report_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> cyc_type != 3'd0);
  // R11
  viol_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(ras_n) != $past(ras_n, 2));
endmodule

bind dcas_dram_model dcas_dram_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .cyc_valid(cyc_valid), .cyc_type(cyc_type), .viol(viol)
);

// File: tb/tb_dcas_dram_model.sv
module tb_dcas_dram_model;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 3, COL_W = 3, DW = 16, RAS_MIN = 4, PRE_MIN = 3;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, lcas_n = 1, ucas_n = 1, we_n = 1, oe_n = 1;
  logic [2:0] addr = '0;
  logic [DW-1:0] dq_in = '0, dq_out;
  logic [1:0] dq_oe;
  logic cyc_valid, viol;
  logic [2:0] cyc_type;

  dcas_dram_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .RAS_MIN(RAS_MIN),
                    .PRE_MIN(PRE_MIN)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cyc_valid(cyc_valid), .cyc_type(cyc_type), .viol(viol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] model [ROWS*COLS];

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [DW-1:0] pat(input int r, input int c);
    return 16'(((r + 1) << 12) | ((c ^ 9) << 8) | (((r * COLS + c) * 5 + 3) & 255));
  endfunction

  function automatic logic [DW-1:0] lmask(input logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

  task automatic open_row(input int r);
    addr = 3'(r); ras_n = 0; step();
    check("R12 no viol on fall", 32'(viol), 0);
    repeat (RAS_MIN - 1) step();
  endtask

  task automatic close_row(input bit exp_rasonly);
    ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1; step();
    check("R11 no viol on rise", 32'(viol), 0);
    if (exp_rasonly) begin
      check("R8 rasonly valid", 32'(cyc_valid), 1);
      check("R8 rasonly code", 32'(cyc_type), 4);
      check("R8 rasonly hiz", 32'(dq_oe), 0);
    end
    repeat (PRE_MIN - 1) step();
  endtask

  task automatic ewrite(input int r, input int c, input logic [1:0] lanes, input logic [DW-1:0] d);
    addr = 3'(c); we_n = 0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; dq_in = d; step();
    check("R4 ewrite valid", 32'(cyc_valid), 1);
    check("R4 ewrite code", 32'(cyc_type), 2);
    check("R4 ewrite hiz", 32'(dq_oe), 0);
    model[r*COLS+c] = (model[r*COLS+c] & ~lmask(lanes)) | (d & lmask(lanes));
    lcas_n = 1; ucas_n = 1; we_n = 1; step();
    check("R4 ewrite hiz after", 32'(dq_oe), 0);
  endtask

  task automatic readc(input int r, input int c, input logic [1:0] lanes);
    addr = 3'(c); we_n = 1; oe_n = 0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; step();
    check("R2 read valid", 32'(cyc_valid), 1);
    check("R2 read code", 32'(cyc_type), 1);
    check("R3 lane enables", 32'(dq_oe), 32'(lanes));
    check("R10 page data", 32'(dq_out & lmask(lanes)), 32'(model[r*COLS+c] & lmask(lanes)));
    lcas_n = 1; ucas_n = 1; step();
    check("R9 off after cas", 32'(dq_oe), 0);
    oe_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    report();
  end

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    check("R13 oe reset", 32'(dq_oe), 0);
    check("R13 valid reset", 32'(cyc_valid), 0);
    check("R13 viol reset", 32'(viol), 0);
    check("R9 standby hiz", 32'(dq_oe), 0);
    repeat (PRE_MIN) step();

    // full-word early writes, one row per RAS cycle
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) ewrite(r, c, 2'b11, pat(r, c));
      close_row(0);
    end
    // page-mode readback, R10
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) readc(r, c, 2'b11);
      close_row(0);
    end
    // byte-lane writes and byte reads, R3 R4
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) ewrite(r, c, 2'((r + c) % 3 + 1), ~pat(c, r));
      for (int c = 0; c < COLS; c++) readc(r, c, 2'((r * 3 + c) % 3 + 1));
      close_row(0);
    end

    // R1 internal strobe merge
    open_row(1);
    addr = 3'd2; oe_n = 0; we_n = 1; lcas_n = 0; step();
    check("R1 first fall reports read", 32'(cyc_type), 1);
    check("R1 lower only", 32'(dq_oe), 1);
    ucas_n = 0; step();
    check("R1 no new report", 32'(cyc_valid), 0);
    check("R1 both lanes", 32'(dq_oe), 3);
    check("R1 word", 32'(dq_out), 32'(model[1*COLS+2]));
    lcas_n = 1; step();
    check("R1 still active", 32'(dq_oe), 2);
    check("R1 no report on lane rise", 32'(cyc_valid), 0);
    ucas_n = 1; step();
    check("R1 last rise ends", 32'(dq_oe), 0);
    addr = 3'd3; lcas_n = 0; step();
    check("R1 new access valid", 32'(cyc_valid), 1);
    check("R1 new access data", 32'(dq_out & 16'h00FF), 32'(model[1*COLS+3] & 16'h00FF));
    lcas_n = 1; oe_n = 1; step();
    close_row(0);

    // R14 output enable gating
    open_row(2);
    addr = 3'd4; oe_n = 0; lcas_n = 0; ucas_n = 0; step();
    check("R14 read on", 32'(dq_oe), 3);
    oe_n = 1; step();
    check("R14 oe high off", 32'(dq_oe), 0);
    oe_n = 0; step();
    check("R14 restored", 32'(dq_oe), 3);
    check("R14 no report", 32'(cyc_valid), 0);
    check("R14 same data", 32'(dq_out), 32'(model[2*COLS+4]));
    lcas_n = 1; ucas_n = 1; oe_n = 1; step();
    close_row(0);

    // R5 read-write on upper lane
    open_row(3);
    addr = 3'd5; oe_n = 0; ucas_n = 0; step();
    check("R5 read first", 32'(cyc_type), 1);
    oe_n = 1; step();
    we_n = 0; dq_in = 16'hBEEF; step();
    check("R5 rw valid", 32'(cyc_valid), 1);
    check("R5 rw code", 32'(cyc_type), 3);
    check("R5 rw hiz", 32'(dq_oe), 0);
    model[3*COLS+5] = (model[3*COLS+5] & 16'h00FF) | 16'hBE00;
    ucas_n = 1; we_n = 1; step();
    readc(3, 5, 2'b11);
    close_row(0);

    // R6 CBR refresh
    lcas_n = 0; step();
    check("R9 cas low ras high hiz", 32'(dq_oe), 0);
    addr = 3'd7; dq_in = 16'h1234; ras_n = 0; step();
    check("R6 cbr valid", 32'(cyc_valid), 1);
    check("R6 cbr code", 32'(cyc_type), 5);
    check("R6 cbr hiz", 32'(dq_oe), 0);
    repeat (RAS_MIN - 1) step();
    ras_n = 1; step();
    lcas_n = 1; step();
    repeat (PRE_MIN) step();

    // R7 hidden refresh
    open_row(4);
    addr = 3'd6; oe_n = 0; lcas_n = 0; ucas_n = 0; step();
    ras_n = 1; step();
    check("R7 held over ras rise", 32'(dq_oe), 3);
    repeat (PRE_MIN - 1) step();
    ras_n = 0; step();
    check("R7 hidden valid", 32'(cyc_valid), 1);
    check("R7 hidden code", 32'(cyc_type), 6);
    check("R7 hidden drives", 32'(dq_oe), 3);
    check("R7 hidden data", 32'(dq_out), 32'(model[4*COLS+6]));
    repeat (RAS_MIN - 1) step();
    check("R7 still driven", 32'(dq_oe), 3);
    ras_n = 1; lcas_n = 1; ucas_n = 1; oe_n = 1; step();
    check("R9 end hiz", 32'(dq_oe), 0);
    repeat (PRE_MIN - 1) step();

    // R8 row-only refresh
    open_row(5);
    close_row(1);

    // R11 short RAS low
    ras_n = 0; step(); step();
    ras_n = 1; step();
    check("R11 short low flagged", 32'(viol), 1);
    step();
    check("R11 pulse one clock", 32'(viol), 0);
    repeat (PRE_MIN) step();

    // R12 short precharge
    ras_n = 0; repeat (RAS_MIN) step();
    ras_n = 1; step();
    check("R12 rise ok", 32'(viol), 0);
    ras_n = 0; step();
    check("R12 short precharge flagged", 32'(viol), 1);
    repeat (RAS_MIN - 1) step();
    close_row(1);

    // final readback: CBR stored nothing, R6
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) readc(r, c, 2'b11);
      close_row(0);
    end
    report();
  end
endmodule